// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs the full erase and erase-verify procedure on a set of flash blocks without software stepping through it. The caller loads nine programmable wait counts, a maximum erase count and a watchdog limit, then presents a block mask with a one-cycle start pulse. The sequencer raises the software-write enable, selects one block at a time, walks the erase-setup, erase and clear strobes with a timed gap at every edge, and then enters verify mode. In verify mode it writes all-ones to each word as a dummy write, waits, reads the word back, and re-erases the block when any bit is still zero.

States: IDLE, SWE_SET (enable on, wait), PICK (choose lowest pending block), SEL (block select on), ESU_SET (setup wait), ERASE (erase pulse), E_CLR (erase off, wait), ESU_CLR (setup off, wait), EV_SET (verify on, wait), DWR (dummy write), DWR_WAIT (write-to-read wait), READ (issue read), CHECK (judge word), EV_CLR (verify off, wait), SWE_CLR (enable off, final wait). Transitions: IDLE->SWE_SET on start; SWE_SET->PICK; PICK->SEL when a block is pending, else PICK->SWE_CLR; SEL->ESU_SET->ERASE->E_CLR->ESU_CLR->EV_SET->DWR->DWR_WAIT->READ->CHECK; CHECK->DWR on a good word that is not the last, CHECK->EV_CLR on a good last word, CHECK->ESU_SET on a bad word with erases left, CHECK->IDLE (fail) on a bad word with none left; EV_CLR->PICK; SWE_CLR->IDLE (done); ESU_SET, ERASE or E_CLR->IDLE (fail) on a watchdog expiry.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset busy, done, fail, every strobe, the block select, the watchdog arm and both memory strobes are low.
- R2: A start pulse is accepted only in IDLE; a start while busy changes neither the blocks erased nor the result.
- R3: Strobes follow enable, select, setup, erase; erase rises max(t_esu,1) cycles after setup rises, setup falls max(t_eclr,1) cycles after erase falls, verify rises max(t_esuclr,1) cycles after setup falls, setup rises at least t_swe cycles after enable rises, erase is high only under setup and enable, and verify is never high together with setup.
- R4: The erase strobe stays high exactly max(t_erase,1) cycles and never longer.
- R5: Exactly one block-select bit is high whenever setup or verify is high.
- R6: The watchdog arm is high exactly while setup is high; when it has been high for wdt_lim cycles the run aborts with fail set, fail_blk giving the current block and all strobes low.
- R7: Before each verify read a dummy write of 16'hFFFF goes to the same address while verify is high; the read follows the write by at least t_dwr cycles, and block b covers addresses BLK_BASE[b] to BLK_BASE[b]+BLK_WORDS-1 in ascending order; read data is taken the cycle after the read strobe.
- R8: A word equal to 16'hFFFF advances to the next address; a word with any zero bit re-erases the block and verification restarts at its first word.
- R9: A block is erased at most max_erase times; a failed verify after the last permitted erase ends the run with fail set and fail_blk equal to that block index, and no later block is touched.
- R10: Selected blocks are handled one at a time from the lowest mask bit upward.
- R11: Enable falls at least t_evclr cycles after verify falls; done rises at least t_sweclr cycles after enable falls; done and fail hold until the next accepted start.
- R12: A start with an empty mask completes with done and no erase pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| blk_mask_i | input | NBLK | Blocks to erase, sampled at start |
| t_swe_i | input | CW | Wait after enable set |
| t_esu_i | input | CW | Setup wait before erase |
| t_erase_i | input | CW | Erase pulse length |
| t_eclr_i | input | CW | Wait after erase cleared |
| t_esuclr_i | input | CW | Wait after setup cleared |
| t_evset_i | input | CW | Wait after verify set |
| t_dwr_i | input | CW | Dummy write to read wait |
| t_evclr_i | input | CW | Wait after verify cleared |
| t_sweclr_i | input | CW | Wait after enable cleared |
| max_erase_i | input | RW | Maximum erases per block |
| wdt_lim_i | input | CW | Watchdog limit in cycles |
| swe_o | output | 1 | Software-write enable strobe |
| esu_o | output | 1 | Erase setup strobe |
| erase_o | output | 1 | Erase strobe |
| ev_o | output | 1 | Erase-verify strobe |
| blk_sel_o | output | NBLK | One-hot block select |
| wdt_arm_o | output | 1 | Watchdog armed |
| mem_we_o | output | 1 | Dummy write strobe |
| mem_re_o | output | 1 | Verify read strobe |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 16 | Dummy write data |
| mem_rdata_i | input | 16 | Verify read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished with all blocks erased |
| fail_o | output | 1 | Run ended in failure |
| fail_blk_o | output | BW | Index of the failing block |

## Verification
The CHECK state decides two things in one cycle: whether the word read back is clean and whether the block's erase budget is spent. The bench provokes this by giving the last word of a block more erases to clear than max_erase allows, so the failing read lands on the final permitted erase; the scoreboard then expects exactly max_erase pulses on that block, fail with that index and no pulse on higher blocks. A second collision is a start pulse arriving mid-run, judged by an unchanged pulse sequence and result.

// File: rtl/fes_pkg.sv
package fes_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_SWE_SET, ST_PICK, ST_SEL, ST_ESU_SET, ST_ERASE, ST_E_CLR,
        ST_ESU_CLR, ST_EV_SET, ST_DWR, ST_DWR_WAIT, ST_READ, ST_CHECK,
        ST_EV_CLR, ST_SWE_CLR
    } fes_state_e;
endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= load_val_i;
        else if (cnt_q > 1)    cnt_q <= cnt_q - 1'b1;
    end

    // A count of zero or one gives a single-cycle dwell.
    assign expired_o = (cnt_q <= 1);
endmodule

// File: rtl/fes_pick.sv
module fes_pick #(
    parameter int NBLK = 4,
    parameter int BW   = 2
) (
    input  logic [NBLK-1:0] pend_i,
    output logic            found_o,
    output logic [BW-1:0]   idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // Scan downward so the lowest pending bit is the last one written.
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = BW'(i);
            end
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int AW        = 6,
    parameter int BLK_WORDS = 8,
    parameter int CW        = 12,
    parameter int RW        = 4,
    parameter logic [NBLK*AW-1:0] BLK_BASE = {6'd48, 6'd32, 6'd16, 6'd0},
    localparam int BW = $clog2(NBLK),
    localparam int WW = $clog2(BLK_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NBLK-1:0] blk_mask_i,
    input  logic [CW-1:0]   t_swe_i,
    input  logic [CW-1:0]   t_esu_i,
    input  logic [CW-1:0]   t_erase_i,
    input  logic [CW-1:0]   t_eclr_i,
    input  logic [CW-1:0]   t_esuclr_i,
    input  logic [CW-1:0]   t_evset_i,
    input  logic [CW-1:0]   t_dwr_i,
    input  logic [CW-1:0]   t_evclr_i,
    input  logic [CW-1:0]   t_sweclr_i,
    input  logic [RW-1:0]   max_erase_i,
    input  logic [CW-1:0]   wdt_lim_i,
    output logic            swe_o,
    output logic            esu_o,
    output logic            erase_o,
    output logic            ev_o,
    output logic [NBLK-1:0] blk_sel_o,
    output logic            wdt_arm_o,
    output logic            mem_we_o,
    output logic            mem_re_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [15:0]     mem_wdata_o,
    input  logic [15:0]     mem_rdata_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            fail_o,
    output logic [BW-1:0]   fail_blk_o
);
    fes_state_e      state_q, state_d;
    logic [NBLK-1:0] pend_q;
    logic [BW-1:0]   cur_q, pick_idx, fblk_q;
    logic [WW-1:0]   word_q;
    logic [RW-1:0]   tries_q;
    logic [CW-1:0]   wd_q, wait_val;
    logic            done_q, fail_q, found, t_exp;
    logic            rd_ok, last_word, abort, fail_now;

    fes_pick #(.NBLK(NBLK), .BW(BW)) u_pick (
        .pend_i (pend_q),
        .found_o(found),
        .idx_o  (pick_idx)
    );

    fes_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (state_d != state_q),
        .load_val_i(wait_val),
        .expired_o (t_exp)
    );

    assign rd_ok     = &mem_rdata_i;
    assign last_word = (word_q == WW'(BLK_WORDS - 1));
    assign abort     = wdt_arm_o && (wd_q >= wdt_lim_i);
    assign fail_now  = abort || (state_q == ST_CHECK && !rd_ok && tries_q >= max_erase_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_SWE_SET;
            ST_SWE_SET:  if (t_exp) state_d = ST_PICK;
            ST_PICK:     state_d = found ? ST_SEL : ST_SWE_CLR;
            ST_SEL:      state_d = ST_ESU_SET;
            ST_ESU_SET:  if (t_exp) state_d = ST_ERASE;
            ST_ERASE:    if (t_exp) state_d = ST_E_CLR;
            ST_E_CLR:    if (t_exp) state_d = ST_ESU_CLR;
            ST_ESU_CLR:  if (t_exp) state_d = ST_EV_SET;
            ST_EV_SET:   if (t_exp) state_d = ST_DWR;
            ST_DWR:      state_d = ST_DWR_WAIT;
            ST_DWR_WAIT: if (t_exp) state_d = ST_READ;
            ST_READ:     state_d = ST_CHECK;
            ST_CHECK: begin
                if (rd_ok)         state_d = last_word ? ST_EV_CLR : ST_DWR;
                else if (fail_now) state_d = ST_IDLE;
                else               state_d = ST_ESU_SET;
            end
            ST_EV_CLR:   if (t_exp) state_d = ST_PICK;
            ST_SWE_CLR:  if (t_exp) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // Dwell count of the state being entered
    always_comb begin
        unique case (state_d)
            ST_SWE_SET:  wait_val = t_swe_i;
            ST_ESU_SET:  wait_val = t_esu_i;
            ST_ERASE:    wait_val = t_erase_i;
            ST_E_CLR:    wait_val = t_eclr_i;
            ST_ESU_CLR:  wait_val = t_esuclr_i;
            ST_EV_SET:   wait_val = t_evset_i;
            ST_DWR_WAIT: wait_val = t_dwr_i;
            ST_EV_CLR:   wait_val = t_evclr_i;
            ST_SWE_CLR:  wait_val = t_sweclr_i;
            default:     wait_val = CW'(1);
        endcase
    end

    // State register and sequencing state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cur_q   <= '0;
            word_q  <= '0;
            tries_q <= '0;
            wd_q    <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            fblk_q  <= '0;
        end else begin
            state_q <= state_d;
            wd_q    <= wdt_arm_o ? wd_q + 1'b1 : '0;
            if (state_q == ST_IDLE && start_i) begin
                pend_q <= blk_mask_i;
                done_q <= 1'b0;
                fail_q <= 1'b0;
                fblk_q <= '0;
            end
            if (state_q == ST_PICK && found) begin
                cur_q   <= pick_idx;
                tries_q <= '0;
            end
            if (state_q == ST_ESU_SET) word_q <= '0;
            if (state_d == ST_ERASE && state_q != ST_ERASE) tries_q <= tries_q + 1'b1;
            if (state_q == ST_CHECK && rd_ok && !last_word) word_q <= word_q + 1'b1;
            if (state_q == ST_EV_CLR) pend_q[cur_q] <= 1'b0;
            if (state_q == ST_SWE_CLR && t_exp) done_q <= 1'b1;
            if (fail_now) begin
                fail_q <= 1'b1;
                fblk_q <= cur_q;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        swe_o     = 1'b1;
        esu_o     = 1'b0;
        erase_o   = 1'b0;
        ev_o      = 1'b0;
        wdt_arm_o = 1'b0;
        mem_we_o  = 1'b0;
        mem_re_o  = 1'b0;
        blk_sel_o = '0;
        unique case (state_q)
            ST_IDLE, ST_SWE_CLR: swe_o = 1'b0;
            ST_SEL:              blk_sel_o = NBLK'(1) << cur_q;
            ST_ESU_SET, ST_E_CLR: begin
                esu_o = 1'b1; wdt_arm_o = 1'b1; blk_sel_o = NBLK'(1) << cur_q;
            end
            ST_ERASE: begin
                esu_o = 1'b1; erase_o = 1'b1; wdt_arm_o = 1'b1;
                blk_sel_o = NBLK'(1) << cur_q;
            end
            ST_ESU_CLR:          blk_sel_o = NBLK'(1) << cur_q;
            ST_EV_SET, ST_DWR_WAIT, ST_CHECK: begin
                ev_o = 1'b1; blk_sel_o = NBLK'(1) << cur_q;
            end
            ST_DWR: begin
                ev_o = 1'b1; mem_we_o = 1'b1; blk_sel_o = NBLK'(1) << cur_q;
            end
            ST_READ: begin
                ev_o = 1'b1; mem_re_o = 1'b1; blk_sel_o = NBLK'(1) << cur_q;
            end
            default: ;
        endcase
    end

    assign mem_addr_o  = BLK_BASE[cur_q*AW +: AW] + AW'(word_q);
    assign mem_wdata_o = 16'hFFFF;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign fail_blk_o  = fblk_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int NBLK = 4,
    parameter int CW   = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            swe_o,
    input logic            esu_o,
    input logic            erase_o,
    input logic            ev_o,
    input logic [NBLK-1:0] blk_sel_o,
    input logic            wdt_arm_o,
    input logic            mem_we_o,
    input logic            mem_re_o,
    input logic [15:0]     mem_wdata_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            fail_o,
    input logic [CW-1:0]   t_erase_i
);
    logic [CW-1:0] elen_q, elim;

    assign elim = (t_erase_i == '0) ? CW'(1) : t_erase_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       elen_q <= '0;
        else if (erase_o) elen_q <= elen_q + 1'b1;
        else              elen_q <= '0;
    end

    assert_erase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_o |-> (elen_q < elim));
    assert_erase_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_o |-> (esu_o && swe_o));
    assert_verify_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |-> !esu_o);
    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (esu_o || ev_o) |-> $onehot(blk_sel_o));
    assert_arm_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_arm_o == esu_o);
    assert_dummy_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (ev_o && (&mem_wdata_o)));
    assert_read_in_verify_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |-> ev_o);
    assert_fail_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !busy_o);
    assert_done_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!swe_o && !fail_o));
endmodule

bind flash_erase_seq fes_checker #(.NBLK(NBLK), .CW(CW)) u_fes_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .swe_o      (swe_o),
    .esu_o      (esu_o),
    .erase_o    (erase_o),
    .ev_o       (ev_o),
    .blk_sel_o  (blk_sel_o),
    .wdt_arm_o  (wdt_arm_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_wdata_o(mem_wdata_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .t_erase_i  (t_erase_i)
);

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int WPB = 8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0] mask = '0;
    logic [11:0] c_swe, c_esu, c_er, c_ecl, c_escl, c_evs, c_dwr, c_evc, c_swc, c_wdl;
    logic [3:0] c_max;
    logic swe, esu, er, ev, arm, we, re, busy, done, fail;
    logic [3:0] sel;
    logic [5:0] addr;
    logic [15:0] wdata, rdata = '0;
    logic [1:0] fblk;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_seq u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(mask),
        .t_swe_i(c_swe), .t_esu_i(c_esu), .t_erase_i(c_er), .t_eclr_i(c_ecl),
        .t_esuclr_i(c_escl), .t_evset_i(c_evs), .t_dwr_i(c_dwr), .t_evclr_i(c_evc),
        .t_sweclr_i(c_swc), .max_erase_i(c_max), .wdt_lim_i(c_wdl),
        .swe_o(swe), .esu_o(esu), .erase_o(er), .ev_o(ev), .blk_sel_o(sel),
        .wdt_arm_o(arm), .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
        .fail_o(fail), .fail_blk_o(fblk)
    );

    int checks = 0, failures = 0;
    int need [64];
    int pulse_q [$];
    typedef struct { bit d; bit f; int b; } res_t;
    res_t res_q [$];
    bit trunc = 0;

    function automatic int mx1(int v); return (v < 1) ? 1 : v; endfunction
    function automatic int blk_of(logic [3:0] s);
        for (int i = 0; i < NB; i++) if (s[i]) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural flash array: registered read, all-ones once erased enough
    always @(posedge clk) if (re) rdata <= (need[addr] <= 0) ? 16'hFFFF : 16'hFF7F;

    // Monitor / scoreboard consumer
    int cyc = 0, t_swe_r = 0, t_esu_r = 0, t_e_r = 0, t_e_f = 0, t_esu_f = 0;
    int t_swe_f = 0, t_ev_f = 0, t_we = -100, we_addr = -1, exp_word = 0;
    logic p_swe = 0, p_esu = 0, p_e = 0, p_ev = 0, p_busy = 0, p_done = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (swe && !p_swe) t_swe_r = cyc;
            if (!swe && p_swe) begin
                t_swe_f = cyc;
                if (!trunc && !fail) chk(cyc - t_ev_f >= mx1(int'(c_evc)), "R11", "verify-off to enable-off", cyc - t_ev_f, int'(c_evc));
            end
            if (esu && !p_esu) begin
                t_esu_r = cyc;
                chk(cyc - t_swe_r >= int'(c_swe), "R3", "enable to setup gap", cyc - t_swe_r, int'(c_swe));
            end
            if (er && !p_e) begin
                t_e_r = cyc;
                chk(cyc - t_esu_r == mx1(int'(c_esu)), "R3", "setup to erase gap", cyc - t_esu_r, mx1(int'(c_esu)));
            end
            if (!er && p_e) begin
                t_e_f = cyc;
                exp_word = 0;
                if (!trunc) begin
                    chk(cyc - t_e_r == mx1(int'(c_er)), "R4", "erase pulse length", cyc - t_e_r, mx1(int'(c_er)));
                    if (pulse_q.size() == 0) chk(0, "R10", "unexpected erase pulse on block", blk_of(sel), -1);
                    else begin
                        int eb;
                        eb = pulse_q.pop_front();
                        chk(blk_of(sel) == eb, "R10", "erased block", blk_of(sel), eb);
                    end
                    for (int w = 0; w < WPB; w++) need[blk_of(sel)*16 + w]--;
                end
            end
            if (!esu && p_esu && !trunc) begin
                t_esu_f = cyc;
                chk(cyc - t_e_f == mx1(int'(c_ecl)), "R3", "erase-off to setup-off gap", cyc - t_e_f, mx1(int'(c_ecl)));
            end
            if (ev && !p_ev)
                chk(cyc - t_esu_f == mx1(int'(c_escl)), "R3", "setup-off to verify gap", cyc - t_esu_f, mx1(int'(c_escl)));
            if (!ev && p_ev) t_ev_f = cyc;
            if (we) begin
                t_we = cyc; we_addr = int'(addr);
                chk(wdata == 16'hFFFF && ev, "R7", "dummy write data", int'(wdata), 16'hFFFF);
                chk(int'(addr) == blk_of(sel)*16 + exp_word, "R8", "dummy write address", int'(addr), blk_of(sel)*16 + exp_word);
            end
            if (re) begin
                chk(int'(addr) == we_addr, "R7", "read address matches dummy write", int'(addr), we_addr);
                chk(cyc - t_we >= int'(c_dwr), "R7", "write to read gap", cyc - t_we, int'(c_dwr));
                if (need[addr] <= 0) exp_word++;
            end
            if (done && !p_done)
                chk(cyc - t_swe_f >= int'(c_swc), "R11", "enable-off to done gap", cyc - t_swe_f, int'(c_swc));
            if (!busy && p_busy) begin
                if (res_q.size() == 0) chk(0, "R2", "unexpected completion", 1, 0);
                else begin
                    res_t x;
                    x = res_q.pop_front();
                    chk(done == x.d, x.f ? "R9" : "R11", "done flag", int'(done), int'(x.d));
                    chk(fail == x.f, x.f ? "R9" : "R11", "fail flag", int'(fail), int'(x.f));
                    if (x.f) chk(int'(fblk) == x.b, "R9", "failing block", int'(fblk), x.b);
                end
                chk(pulse_q.size() == 0, "R10", "erase pulses left unmatched", pulse_q.size(), 0);
                chk(!swe && !esu && !er && !ev && sel == 0, "R6", "strobes low at end", int'({swe,esu,er,ev}), 0);
            end
        end
        p_swe = swe; p_esu = esu; p_e = er; p_ev = ev; p_busy = busy; p_done = done;
    end

    task automatic set_times(int a, int b, int c, int d, int e, int f, int g, int h, int i);
        c_swe = 12'(a); c_esu = 12'(b); c_er = 12'(c); c_ecl = 12'(d); c_escl = 12'(e);
        c_evs = 12'(f); c_dwr = 12'(g); c_evc = 12'(h); c_swc = 12'(i);
    endtask

    // Driver: pushes expected pulses and result, then starts a run
    task automatic run(logic [3:0] m, int n, bit poke, bit wd);
        bit stop = 0;
        res_t r;
        c_max = 4'(n);
        trunc = wd;
        if (wd) begin
            r.d = 0; r.f = 1; r.b = blk_of(m); res_q.push_back(r);
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (m[b] && !stop) begin
                    int mx = 1;
                    for (int w = 0; w < WPB; w++) if (need[b*16+w] > mx) mx = need[b*16+w];
                    if (mx > n) begin
                        repeat (n) pulse_q.push_back(b);
                        r.d = 0; r.f = 1; r.b = b; res_q.push_back(r);
                        stop = 1;
                    end else repeat (mx) pulse_q.push_back(b);
                end
            end
            if (!stop) begin r.d = 1; r.f = 0; r.b = 0; res_q.push_back(r); end
        end
        @(negedge clk); mask = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        chk(done == 1'b0 && fail == 1'b0, "R11", "status cleared by start", int'({done,fail}), 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            mask = 4'hF; start = 1'b1;   // R2: must be ignored
            @(negedge clk); start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(int v); for (int a = 0; a < 64; a++) need[a] = v; endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        set_times(3, 2, 6, 2, 2, 2, 1, 2, 3);
        c_max = 4'd4; c_wdl = 12'd1000;
        fill(1);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, done, fail, swe, esu, er, ev, arm, we, re} == 0 && sel == 0,
            "R1", "outputs in reset", int'({busy, done, fail, swe, esu, er, ev, arm, we, re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && swe == 0, "R1", "idle after reset", int'({busy,done,swe}), 0);

        // Single block, one erase enough
        fill(1); run(4'b0001, 4, 0, 0);
        repeat (10) @(negedge clk);
        chk(done == 1 && fail == 0, "R11", "done holds", int'({done,fail}), 2);

        // Two blocks, retries on block 1, zero-length waits; R8 R10
        set_times(0, 0, 0, 1, 0, 3, 0, 1, 0);
        fill(1); need[16+5] = 3; need[48] = 0;
        for (int w = 1; w < WPB; w++) need[48+w] = 2;
        run(4'b1010, 4, 0, 0);

        // Retry budget exhausted on the last word; R9
        set_times(2, 1, 4, 1, 1, 1, 2, 1, 2);
        fill(1); need[32+7] = 5;
        run(4'b1100, 3, 0, 0);
        repeat (5) @(negedge clk);
        chk(fail == 1 && done == 0, "R9", "fail holds", int'({fail,done}), 2);

        // Empty mask; R12
        fill(1); run(4'b0000, 4, 0, 0);
        chk(done == 1, "R12", "empty mask completes", int'(done), 1);

        // Start while busy ignored; R2
        fill(2); run(4'b0001, 4, 1, 0);

        // Watchdog abort; R6
        set_times(2, 3, 10, 2, 1, 1, 1, 1, 1);
        c_wdl = 12'd4;
        fill(1); run(4'b0100, 4, 0, 1);
        chk(fail == 1 && int'(fblk) == 2, "R6", "watchdog fail block", int'(fblk), 2);
        chk(!er && !esu && !arm, "R6", "strobes low after abort", int'({er,esu,arm}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule